// File: doc/BRIEF.md
# Extended-Range Phase Error Counter

This block measures how far a monitored clock has drifted in phase against a reference clock. It feeds wander and time-interval-error analysis. Both clocks arrive as single-cycle edge pulses that are already synchronized into the measurement clock domain. Each clock is divided into measurement windows, by default one window per eight unit intervals. A fine timebase restarts on every reference window boundary. Each monitored window boundary samples that timebase, and the sample is the fine phase: the number of measurement-clock steps since the latest reference boundary.

The fine phase alone is ambiguous to within one window. A signed up/down window counter removes that ambiguity. It steps up when successive fine samples wrap past the top of the window and steps down when they wrap below zero. Together the two counters form a two's-complement phase word with a range of many windows. By default that is 256 windows, or 2048 unit intervals.

On each sample tick the combined word is registered to the output with a one-cycle valid pulse. A sticky flag reports that the window counter tried to leave its signed range, and the counter saturates at the limit instead. A synchronous zero request clears every counter and sets a new phase reference point.

Top module: `phase_err_counter`

## Requirements
- R1: While reset is asserted, `phase_o` is 0, `phase_vld_o` is 0 and `range_ovf_o` is 0.
- R2: The fine phase is the count of measurement-clock cycles from the latest reference window boundary to the monitored window boundary, minus one, modulo 2^FINE_W. A monitored boundary that lands exactly on a reference boundary samples the value from before the restart.
- R3: A window boundary is every EDGES_PER_WIN-th edge of a clock, counted from the last zero request. Monitored edges that are not boundaries leave the phase word unchanged.
- R4: When a new fine sample is below the previous one and their modular difference is positive, the window counter increases by one (carry).
- R5: When a new fine sample is above the previous one and their modular difference is negative, the window counter decreases by one (borrow).
- R6: A tick registers the phase word {window count, fine phase} in two's complement to `phase_o`, with the window count in the upper COARSE_W bits. The word is the state from before any update in the same cycle. `phase_vld_o` is high for exactly the cycle after each tick.
- R7: If a carry would take the window count above 2^(COARSE_W-1)-1, the count holds at that limit, the fine part still updates, and `range_ovf_o` sets and stays set until the next zero request.
- R8: If a borrow would take the window count below -2^(COARSE_W-1), the count holds at that limit, the fine part still updates, and `range_ovf_o` sets.
- R9: A zero request clears the window count, the fine phase, both edge dividers, the timebase, the overflow flag and the output register.
- R10: Without a tick, `phase_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; one period is one phase step |
| rst_n | input | 1 | Asynchronous active-low reset |
| zero_i | input | 1 | Synchronous clear that sets the phase reference point |
| ref_edge_i | input | 1 | Reference clock edge pulse |
| mon_edge_i | input | 1 | Monitored clock edge pulse |
| tick_i | input | 1 | Sample strobe for the output word |
| phase_o | output | FINE_W+COARSE_W | Signed phase word, window count above fine phase |
| phase_vld_o | output | 1 | High for one cycle after a tick |
| range_ovf_o | output | 1 | Sticky window-range overflow flag |

## Verification
The bench builds the block with FINE_W=4, COARSE_W=3 and EDGES_PER_WIN=2. That gives 16-step windows, a window-count range of -4 to 3 and a two-edge divider. With this configuration, a few dozen windows of steady drift pass through carries, borrows and both saturation limits. The expected phase is computed as an unwrapped integer from the absolute edge times and then clamped. The same small divider also lets a single odd monitored edge be shown to have no effect.

// File: rtl/pec_pkg.sv
package pec_pkg;

  // Kind of window crossing seen between two successive fine samples.
  typedef enum logic [1:0] {
    WRAP_NONE   = 2'd0,
    WRAP_CARRY  = 2'd1,
    WRAP_BORROW = 2'd2
  } wrap_e;

endpackage

// File: rtl/pec_win_div.sv
// Picks every EDGES-th edge pulse as a window boundary.
module pec_win_div #(
  parameter int unsigned EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic edge_i,
  output logic win_o
);

  if (EDGES <= 1) begin : g_pass
    assign win_o = edge_i && !zero_i;
  end else begin : g_cnt
    localparam int unsigned CNT_W = $clog2(EDGES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (zero_i) begin
        cnt_q <= '0;
      end else if (edge_i) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end

    assign win_o = edge_i && !zero_i && (cnt_q == LAST);
  end

endmodule

// File: rtl/pec_fine_timer.sv
// Timebase restarted by reference windows and sampled by monitored windows.
module pec_fine_timer #(
  parameter int unsigned FINE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_i,
  input  logic              ref_win_i,
  output logic [FINE_W-1:0] fine_smp_o
);

  logic [FINE_W-1:0] tb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else if (zero_i || ref_win_i) begin
      tb_q <= '0;
    end else begin
      tb_q <= tb_q + 1'b1;
    end
  end

  // A monitored boundary takes the value held before this edge's update.
  assign fine_smp_o = tb_q;

endmodule

// File: rtl/pec_unwrap.sv
// Fine phase register plus signed window counter with carry, borrow and clamp.
module pec_unwrap
  import pec_pkg::*;
#(
  parameter int unsigned FINE_W   = 14,
  parameter int unsigned COARSE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       zero_i,
  input  logic                       smp_i,
  input  logic [FINE_W-1:0]          fine_new_i,
  output logic [FINE_W-1:0]          fine_o,
  output logic signed [COARSE_W-1:0] coarse_o,
  output logic                       ovf_o
);

  localparam logic signed [COARSE_W:0] C_MAX = (COARSE_W+1)'((1 << (COARSE_W - 1)) - 1);
  localparam logic signed [COARSE_W:0] C_MIN = ~C_MAX;
  localparam logic signed [COARSE_W:0] C_ONE = (COARSE_W+1)'(1);

  // Classify the step between the old and new fine samples by modular distance.
  function automatic wrap_e classify(input logic [FINE_W-1:0] nf, input logic [FINE_W-1:0] of);
    logic [FINE_W-1:0] d;
    d = nf - of;
    if (!d[FINE_W-1] && (d != '0) && (nf < of)) return WRAP_CARRY;
    if (d[FINE_W-1] && (nf > of)) return WRAP_BORROW;
    return WRAP_NONE;
  endfunction

  // Window count after the crossing, one bit wider to expose range escapes.
  function automatic logic signed [COARSE_W:0] step_count(input logic signed [COARSE_W-1:0] c,
                                                          input wrap_e k);
    logic signed [COARSE_W:0] e;
    e = {c[COARSE_W-1], c};
    case (k)
      WRAP_CARRY:  return e + C_ONE;
      WRAP_BORROW: return e - C_ONE;
      default:     return e;
    endcase
  endfunction

  logic [FINE_W-1:0]          fine_q;
  logic signed [COARSE_W-1:0] coarse_q;
  logic                       ovf_q;

  wrap_e                      wrap_k;
  logic signed [COARSE_W:0]   c_next;
  logic                       sat_hi;
  logic                       sat_lo;

  assign wrap_k = classify(fine_new_i, fine_q);
  assign c_next = step_count(coarse_q, wrap_k);
  assign sat_hi = (c_next > C_MAX);
  assign sat_lo = (c_next < C_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q   <= '0;
      coarse_q <= '0;
      ovf_q    <= 1'b0;
    end else if (zero_i) begin
      fine_q   <= '0;
      coarse_q <= '0;
      ovf_q    <= 1'b0;
    end else if (smp_i) begin
      fine_q <= fine_new_i;
      if (sat_hi) begin
        coarse_q <= C_MAX[COARSE_W-1:0];
        ovf_q    <= 1'b1;
      end else if (sat_lo) begin
        coarse_q <= C_MIN[COARSE_W-1:0];
        ovf_q    <= 1'b1;
      end else begin
        coarse_q <= c_next[COARSE_W-1:0];
      end
    end
  end

  assign fine_o   = fine_q;
  assign coarse_o = coarse_q;
  assign ovf_o    = ovf_q;

  AST_CARRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i && !zero_i && (wrap_k == WRAP_CARRY) && !sat_hi
    |=> (coarse_q - $past(coarse_q)) == COARSE_W'(1)); // R4

  AST_BORROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i && !zero_i && (wrap_k == WRAP_BORROW) && !sat_lo
    |=> ($past(coarse_q) - coarse_q) == COARSE_W'(1)); // R5

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i && !zero_i && sat_hi |=> ovf_q && (coarse_q == C_MAX[COARSE_W-1:0])); // R7

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i && !zero_i && sat_lo |=> ovf_q && (coarse_q == C_MIN[COARSE_W-1:0])); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !zero_i |=> ovf_q); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (coarse_q == '0) && (fine_q == '0) && !ovf_q); // R9

endmodule

// File: rtl/phase_err_counter.sv
// Extended-range phase error counter: dividers, fine timebase, window unwrap, output stage.
module phase_err_counter #(
  parameter int unsigned FINE_W        = 14,
  parameter int unsigned COARSE_W      = 8,
  parameter int unsigned EDGES_PER_WIN = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         zero_i,
  input  logic                         ref_edge_i,
  input  logic                         mon_edge_i,
  input  logic                         tick_i,
  output logic [FINE_W+COARSE_W-1:0]   phase_o,
  output logic                         phase_vld_o,
  output logic                         range_ovf_o
);

  localparam int unsigned PW = FINE_W + COARSE_W;

  logic                       ref_win;
  logic                       mon_win;
  logic [FINE_W-1:0]          fine_smp;
  logic [FINE_W-1:0]          fine_cur;
  logic signed [COARSE_W-1:0] coarse_cur;
  logic                       ovf_cur;

  pec_win_div #(.EDGES(EDGES_PER_WIN)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .zero_i(zero_i), .edge_i(ref_edge_i), .win_o(ref_win)
  );

  pec_win_div #(.EDGES(EDGES_PER_WIN)) u_mon_div (
    .clk(clk), .rst_n(rst_n), .zero_i(zero_i), .edge_i(mon_edge_i), .win_o(mon_win)
  );

  pec_fine_timer #(.FINE_W(FINE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .zero_i(zero_i), .ref_win_i(ref_win), .fine_smp_o(fine_smp)
  );

  pec_unwrap #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_unwrap (
    .clk(clk), .rst_n(rst_n), .zero_i(zero_i), .smp_i(mon_win),
    .fine_new_i(fine_smp), .fine_o(fine_cur), .coarse_o(coarse_cur), .ovf_o(ovf_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o     <= '0;
      phase_vld_o <= 1'b0;
    end else if (zero_i) begin
      phase_o     <= '0;
      phase_vld_o <= 1'b0;
    end else begin
      phase_vld_o <= tick_i;
      if (tick_i) begin
        phase_o <= PW'({coarse_cur, fine_cur});
      end
    end
  end

  assign range_ovf_o = ovf_cur;

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !zero_i |=> phase_vld_o); // R6

  AST_NO_VALID_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !phase_vld_o); // R6

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !zero_i |=> $stable(phase_o)); // R10

endmodule

// File: tb/test_phase_err_counter.sv
module test_phase_err_counter;

  localparam int unsigned FW = 4;
  localparam int unsigned CW = 3;
  localparam int unsigned EW = 2;
  localparam int unsigned PW = FW + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zero_i = 1'b0;
  logic ref_edge_i = 1'b0;
  logic mon_edge_i = 1'b0;
  logic tick_i = 1'b0;
  logic [PW-1:0] phase_o;
  logic phase_vld_o;
  logic range_ovf_o;

  int total = 0;
  int bad = 0;
  int cyc_n = 0;
  logic finished = 1'b0;
  logic [PW-1:0] exp_out = '0;

  always #4 clk = ~clk;

  phase_err_counter #(.FINE_W(FW), .COARSE_W(CW), .EDGES_PER_WIN(EW)) i_phase_err_counter (
    .clk(clk), .rst_n(rst_n), .zero_i(zero_i), .ref_edge_i(ref_edge_i),
    .mon_edge_i(mon_edge_i), .tick_i(tick_i), .phase_o(phase_o),
    .phase_vld_o(phase_vld_o), .range_ovf_o(range_ovf_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // Expected word from the unwrapped phase in steps: clamp window count, keep low bits.
  function automatic logic [PW-1:0] enc(input int p);
    int c;
    c = p >>> FW;
    if (c > 3) c = 3;
    if (c < -4) c = -4;
    return {CW'(c), FW'(p)};
  endfunction

  // One measurement cycle: drive at negedge, check after the next posedge.
  task automatic cyc(input logic r, input logic m, input logic t, input string tag);
    ref_edge_i = r;
    mon_edge_i = m;
    tick_i = t;
    @(posedge clk);
    @(negedge clk);
    cyc_n++;
    ref_edge_i = 1'b0;
    mon_edge_i = 1'b0;
    tick_i = 1'b0;
    if (t) begin
      check(phase_vld_o == 1'b1, {tag, " R6 valid"}, int'(phase_vld_o), 1);
      check(phase_o == exp_out, {tag, " R6 word"}, int'(phase_o), int'(exp_out));
    end else begin
      check(phase_vld_o == 1'b0, "R6 idle valid", int'(phase_vld_o), 0);
      check(phase_o == exp_out, "R10 hold", int'(phase_o), int'(exp_out));
    end
  endtask

  task automatic do_clear();
    zero_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc_n++;
    zero_i = 1'b0;
    exp_out = '0;
    check(phase_o == '0, "R9 clear word", int'(phase_o), 0);
    check(phase_vld_o == 1'b0, "R9 clear valid", int'(phase_vld_o), 0);
    check(range_ovf_o == 1'b0, "R9 clear flag", int'(range_ovf_o), 0);
  endtask

  // Steady drift: reference edges every 8 cycles, monitored edges every 8+dd cycles.
  task automatic run_drift(input int off, input int dd, input int nwin, input logic exp_ovf,
                           input string tag);
    int s, nm, jm, p, mprev, t_end;
    logic r, m, t;
    logic [PW-1:0] st;
    do_clear();
    s = cyc_n + 2;
    nm = s + off;
    jm = 0;
    p = 0;
    mprev = 0;
    st = '0;
    t_end = s + off + (2 * nwin - 1) * (8 + dd) + 7;
    while (cyc_n < t_end) begin
      r = (cyc_n >= s) && (((cyc_n - s) % 8) == 0);
      m = (jm < 2 * nwin) && (cyc_n == nm);
      t = ((cyc_n % 5) == 0);
      if (t) exp_out = st;
      if (m) begin
        jm++;
        if ((jm % 2) == 0) begin
          if (jm == 2) p = off + dd - 1;
          else p = p + (cyc_n - mprev) - 16;
          mprev = cyc_n;
          st = enc(p);
        end
        nm = cyc_n + 8 + dd;
      end
      cyc(r, m, t, tag);
    end
    check(range_ovf_o == exp_ovf, {tag, " flag"}, int'(range_ovf_o), int'(exp_ovf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(phase_o == '0, "R1 reset word", int'(phase_o), 0);
    check(phase_vld_o == 1'b0, "R1 reset valid", int'(phase_vld_o), 0);
    check(range_ovf_o == 1'b0, "R1 reset flag", int'(range_ovf_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: one monitored edge is not a boundary; the second samples the timebase (5).
    do_clear();
    cyc(1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b1, 1'b0, "R3");
    cyc(1'b0, 1'b0, 1'b0, "R3");
    exp_out = '0;
    cyc(1'b0, 1'b0, 1'b1, "R3 odd edge");
    cyc(1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b1, 1'b0, "R3");
    cyc(1'b0, 1'b0, 1'b0, "R3");
    exp_out = PW'(5);
    cyc(1'b0, 1'b0, 1'b1, "R3 R2 boundary");

    run_drift(2, 2, 8, 1'b0, "R2 R4 up");
    run_drift(4, -3, 8, 1'b0, "R2 R5 down");
    run_drift(3, 3, 14, 1'b1, "R4 R7 top");
    run_drift(5, -3, 14, 1'b1, "R5 R8 bottom");
    run_drift(1, 1, 10, 1'b0, "R2 R4 slow");
    run_drift(8, -1, 10, 1'b0, "R2 R5 slow");
    run_drift(1, 0, 6, 1'b0, "R2 still");
    do_clear();

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc_n, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule